// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one capture/compare channel that sits beside a shared 16-bit timer counter. The counter value, its count direction, an up-down-mode flag and a channel-0 compare-equal strobe come in from outside. A small byte-wide register port gives access to an 8-bit control register and to a 16-bit capture/compare value. The value register is written one byte at a time, and its low byte passes through a staging buffer.

In capture mode the channel synchronizes an external pin and copies the counter into the value register on the selected edges. A radio event strobe can be used as the capture source in place of the pin. In compare mode it drives a registered output pin using one of seven match actions, plus an initialize command. Some of those actions depend on the count direction, on a counter-zero condition, or on the channel-0 match. In compare mode a new compare value does not take effect when it is written. It waits until the counter next reads zero. Every capture or compare match produces a one-cycle interrupt request, gated by a mask bit.

Top module: `cc_channel`

## Requirements
- R1: After reset the control register reads 0x40 (mask set, all else 0), the value register reads 0x0000, and `out_o` and `irq_o` are 0.
- R2: Control layout: bit 7 radio source, bit 6 interrupt mask, bits 5:3 compare action, bit 2 mode (1 = compare), bits 1:0 edge select. A write with action 111 keeps the stored action and drives `out_o` to 0 at the same edge.
- R3: In capture mode (bit 2 = 0) with the pin source, the pin passes through two sync flops. Edge select 01 captures on rising edges, 10 on falling edges, 11 on both and 00 never. The counter is loaded three edges after the pin changes. In capture mode `out_o` does not change.
- R4: With bit 7 set, each cycle with `radio_evt_i` high captures the counter when the edge select is nonzero, and pin edges are ignored.
- R5: In compare mode a match (counter equals value) applies the action at the next edge: 000 sets `out_o`, 001 clears it, 010 toggles it.
- R6: Action 011 in up-down mode sets on a match counting up and clears on a match counting down. Outside up-down mode it sets on a match and clears at counter 0, and the match wins if both occur. Action 100 is the mirror of 011.
- R7: Action 101 clears on `ch0_match_i` and sets on the own match. Action 110 sets on `ch0_match_i` and clears on the own match. The own match wins if both occur.
- R8: Address 1 is the low byte and address 2 the high byte. A low-byte write only fills a staging byte. Reads of address 1 return the active value's low byte, and address 3 reads 0.
- R9: In compare mode a high-byte write queues {high, staged low} and leaves the value unchanged. The queued value is applied in a cycle with the counter at 0 and no high-byte write.
- R10: In capture mode a high-byte write loads {high, staged low} at once. A newer compare-mode high-byte write replaces a queued one.
- R11: `irq_o` is high for one cycle after each capture or compare match, and only when mask bit 6 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Shared timer counter value |
| cnt_down_i | input | 1 | Counter is counting down |
| updown_mode_i | input | 1 | Counter runs in up-down mode |
| ch0_match_i | input | 1 | Channel-0 compare-equal strobe |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| radio_evt_i | input | 1 | Radio capture event strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register select: 0 ctrl, 1 low, 2 high |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| out_o | output | 1 | Compare output pin |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The bench aims at the deferral of compare values. A design that loaded the value straight away, or dropped a replaced pending value, would match on the wrong count and read back the wrong high byte. It drives the counter to 0, to the live value and to the pending value under random direction and channel-0 strobes. A wrong priority between match, zero and channel-0 would then leave `out_o` at the wrong level. Directed capture runs step through every edge select and the radio source, so a missing sync stage or a swapped edge decode would latch the wrong count. The bench also checks that an initialize write forces the pin low while the stored action stays the same, and that reads of the low byte never return the staging byte.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [2:0] {
    ACT_SET     = 3'b000,
    ACT_CLR     = 3'b001,
    ACT_TGL     = 3'b010,
    ACT_UP_SET  = 3'b011,
    ACT_UP_CLR  = 3'b100,
    ACT_C0_CLR  = 3'b101,
    ACT_C0_SET  = 3'b110,
    ACT_INIT    = 3'b111
  } cmp_act_e;

  typedef struct packed {
    logic     radio_src;
    logic     irq_en;
    cmp_act_e act;
    logic     cmp_mode;
    logic [1:0] edge_sel;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{radio_src: 1'b0, irq_en: 1'b1, act: ACT_SET,
                                 cmp_mode: 1'b0, edge_sel: 2'b00};

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LO   = 2'd1;
  localparam logic [1:0] ADDR_HI   = 2'd2;
endpackage

// File: rtl/cc_capture.sv
module cc_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic       radio_i,
  input  logic       en_i,
  input  logic       radio_sel_i,
  input  logic [1:0] edge_sel_i,
  output logic       evt_o
);
  logic [SYNC_STAGES:0] sh_q;
  logic rise, fall, pin_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], pin_i};
  end

  // edge taken between last sync stage and one extra history flop
  assign rise    = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign fall    = ~sh_q[SYNC_STAGES-1] & sh_q[SYNC_STAGES];
  assign pin_evt = (edge_sel_i[0] & rise) | (edge_sel_i[1] & fall);
  assign evt_o   = en_i & (radio_sel_i ? (radio_i & (|edge_sel_i)) : pin_evt);
endmodule

// File: rtl/cc_regs.sv
module cc_regs
  import cc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W/2-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cap_evt_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] val_o,
  output logic [CNT_W/2-1:0] lo_o,
  output logic             pend_o,
  output logic [CNT_W-1:0] pend_val_o,
  output logic             init_o,
  output logic [CNT_W/2-1:0] rdata_o
);
  localparam int BYTE_W = CNT_W / 2;

  ctrl_t ctrl_q, ctrl_d;
  logic [BYTE_W-1:0] lo_q;
  logic [CNT_W-1:0]  val_q, pv_q;
  logic pend_q, wr_ctrl, wr_lo, wr_hi, cnt_zero;

  assign wr_ctrl  = we_i && addr_i == ADDR_CTRL;
  assign wr_lo    = we_i && addr_i == ADDR_LO;
  assign wr_hi    = we_i && addr_i == ADDR_HI;
  assign cnt_zero = cnt_i == '0;
  assign init_o   = wr_ctrl && cmp_act_e'(wdata_i[5:3]) == ACT_INIT;

  always_comb begin
    ctrl_d = ctrl_t'(wdata_i[7:0]);
    if (init_o) ctrl_d.act = ctrl_q.act;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      lo_q   <= '0;
      val_q  <= '0;
      pv_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_lo)   lo_q   <= wdata_i;
      if (wr_hi) begin
        if (!ctrl_q.cmp_mode) begin
          val_q  <= {wdata_i, lo_q};
          pend_q <= 1'b0;
        end else begin
          pv_q   <= {wdata_i, lo_q};
          pend_q <= 1'b1;
        end
      end else if (pend_q && cnt_zero) begin
        val_q  <= pv_q;
        pend_q <= 1'b0;
      end else if (cap_evt_i) begin
        val_q  <= cnt_i;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_LO:   rdata_o = val_q[BYTE_W-1:0];
      ADDR_HI:   rdata_o = val_q[CNT_W-1:BYTE_W];
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign val_o      = val_q;
  assign lo_o       = lo_q;
  assign pend_o     = pend_q;
  assign pend_val_o = pv_q;
endmodule

// File: rtl/cc_compare.sv
module cc_compare
  import cc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             mode_i,
  input  cmp_act_e         act_i,
  input  logic             updown_i,
  input  logic             down_i,
  input  logic             ch0_i,
  input  logic             init_i,
  output logic             match_o,
  output logic             out_o
);
  logic out_q, out_d, zero;

  assign match_o = mode_i && cnt_i == val_i;
  assign zero    = cnt_i == '0;

  // later assignments take priority: own match beats zero and channel-0
  always_comb begin
    out_d = out_q;
    if (mode_i) begin
      unique case (act_i)
        ACT_SET: if (match_o) out_d = 1'b1;
        ACT_CLR: if (match_o) out_d = 1'b0;
        ACT_TGL: if (match_o) out_d = ~out_q;
        ACT_UP_SET: begin
          if (updown_i) begin
            if (match_o) out_d = ~down_i;
          end else begin
            if (zero)    out_d = 1'b0;
            if (match_o) out_d = 1'b1;
          end
        end
        ACT_UP_CLR: begin
          if (updown_i) begin
            if (match_o) out_d = down_i;
          end else begin
            if (zero)    out_d = 1'b1;
            if (match_o) out_d = 1'b0;
          end
        end
        ACT_C0_CLR: begin
          if (ch0_i)   out_d = 1'b0;
          if (match_o) out_d = 1'b1;
        end
        ACT_C0_SET: begin
          if (ch0_i)   out_d = 1'b1;
          if (match_o) out_d = 1'b0;
        end
        default: out_d = out_q;
      endcase
    end
    if (init_i) out_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= out_d;
  end

  assign out_o = out_q;
endmodule

// File: rtl/cc_channel.sv
module cc_channel
  import cc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  input  logic             updown_mode_i,
  input  logic             ch0_match_i,
  input  logic             cap_pin_i,
  input  logic             radio_evt_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  output logic             out_o,
  output logic             irq_o
);
  localparam int BYTE_W = CNT_W / 2;

  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  val_q, pv_q;
  logic [BYTE_W-1:0] lo_q;
  logic pend_q, init, cap_evt, cmp_match, evt_q;

  cc_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk_i, .rst_ni,
    .pin_i       (cap_pin_i),
    .radio_i     (radio_evt_i),
    .en_i        (~ctrl_q.cmp_mode),
    .radio_sel_i (ctrl_q.radio_src),
    .edge_sel_i  (ctrl_q.edge_sel),
    .evt_o       (cap_evt)
  );

  cc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .cnt_i,
    .cap_evt_i  (cap_evt),
    .ctrl_o     (ctrl_q),
    .val_o      (val_q),
    .lo_o       (lo_q),
    .pend_o     (pend_q),
    .pend_val_o (pv_q),
    .init_o     (init),
    .rdata_o    (reg_rdata_o)
  );

  cc_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk_i, .rst_ni,
    .cnt_i,
    .val_i    (val_q),
    .mode_i   (ctrl_q.cmp_mode),
    .act_i    (ctrl_q.act),
    .updown_i (updown_mode_i),
    .down_i   (cnt_down_i),
    .ch0_i    (ch0_match_i),
    .init_i   (init),
    .match_o  (cmp_match),
    .out_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= cap_evt | cmp_match;
  end

  assign irq_o = evt_q & ctrl_q.irq_en;
endmodule

// File: rtl/cc_channel_chk.sv
module cc_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic [7:0]       wdata_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             ch0_i,
  input logic             out_o,
  input logic             irq_o,
  input logic [7:0]       ctrl,
  input logic [CNT_W-1:0] val,
  input logic [CNT_W/2-1:0] lo,
  input logic             pend,
  input logic [CNT_W-1:0] pend_val,
  input logic             cap_evt,
  input logic             cmp_match
);
  logic init_wr, own_eq;
  assign init_wr = we_i && addr_i == 2'd0 && wdata_i[5:3] == 3'b111;
  assign own_eq  = ctrl[2] && cnt_i == val;

  p_init_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_wr |=> !out_o);
  p_init_keeps_act_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_wr |=> ctrl[5:3] == $past(ctrl[5:3]));
  p_capture_out_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl[2] && !init_wr) |=> $stable(out_o));
  p_set_on_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_eq && ctrl[5:3] == 3'b000 && !init_wr) |=> out_o);
  p_dual_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[2] && ctrl[5:3] == 3'b101 && ch0_i && !own_eq && !init_wr) |=> !out_o);
  p_lo_staged_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd1 && ctrl[2] && !(pend && cnt_i == '0)) |=> $stable(val));
  p_hi_deferred_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd2 && ctrl[2]) |=> $stable(val));
  p_zero_apply_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && cnt_i == '0 && !(we_i && addr_i == 2'd2)) |=> val == $past(pend_val));
  p_hi_direct_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd2 && !ctrl[2]) |=> val == {$past(wdata_i), $past(lo)});
  p_irq_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(cap_evt || cmp_match));
endmodule

bind cc_channel cc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (reg_we_i),
  .addr_i    (reg_addr_i),
  .wdata_i   (reg_wdata_i),
  .cnt_i     (cnt_i),
  .ch0_i     (ch0_match_i),
  .out_o     (out_o),
  .irq_o     (irq_o),
  .ctrl      (ctrl_q),
  .val       (val_q),
  .lo        (lo_q),
  .pend      (pend_q),
  .pend_val  (pv_q),
  .cap_evt   (cap_evt),
  .cmp_match (cmp_match)
);

// File: tb/cc_channel_test.sv
module cc_channel_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [15:0] cnt = '0;
  logic down = 0, updown = 0, ch0 = 0, pin = 0, radio = 0, we = 0;
  logic [1:0] addr = '0;
  logic [7:0] wd = '0;
  logic [7:0] rdata;
  logic out, irq;

  int checks = 0, errs = 0, irq_cnt = 0;
  bit done = 0, model_on = 0;

  logic [7:0]  m_ctrl = 8'h40, m_lo = '0;
  logic [15:0] m_val = '0, m_pv = '0;
  logic m_pend = 0, m_out = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_channel uut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cnt_down_i(down),
    .updown_mode_i(updown), .ch0_match_i(ch0), .cap_pin_i(pin),
    .radio_evt_i(radio), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .out_o(out), .irq_o(irq));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string act_tag(logic [2:0] a);
    case (a)
      3'b000, 3'b001, 3'b010: return "R5";
      3'b011, 3'b100:         return "R6";
      3'b101, 3'b110:         return "R7";
      default:                return "R2";
    endcase
  endfunction

  function automatic logic next_out(logic [2:0] a, logic o, logic m, logic z,
                                    logic c0, logic ud, logic dn);
    logic n = o;
    case (a)
      3'b000: if (m) n = 1;
      3'b001: if (m) n = 0;
      3'b010: if (m) n = ~o;
      3'b011: if (ud) begin if (m) n = ~dn; end
              else begin if (z) n = 0; if (m) n = 1; end
      3'b100: if (ud) begin if (m) n = dn; end
              else begin if (z) n = 1; if (m) n = 0; end
      3'b101: begin if (c0) n = 0; if (m) n = 1; end
      3'b110: begin if (c0) n = 1; if (m) n = 0; end
      default: n = o;
    endcase
    return n;
  endfunction

  function automatic logic [7:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0: return m_ctrl;
      2'd1: return m_val[7:0];
      2'd2: return m_val[15:8];
      default: return 8'h00;
    endcase
  endfunction

  // one clock: predict from pre-edge inputs, sample at the following negedge
  task automatic tick();
    logic mode, match, init, n_irq;
    logic [2:0] act;
    mode  = m_ctrl[2];
    act   = m_ctrl[5:3];
    match = mode && cnt == m_val;
    init  = we && addr == 2'd0 && wd[5:3] == 3'b111;
    m_out = init ? 1'b0 : (mode ? next_out(act, m_out, match, cnt == 0, ch0, updown, down) : m_out);
    if (we && addr == 2'd0) begin
      m_ctrl = wd;
      if (init) m_ctrl[5:3] = act;
    end
    if (we && addr == 2'd2) begin
      if (!mode) begin m_val = {wd, m_lo}; m_pend = 0; end
      else begin m_pv = {wd, m_lo}; m_pend = 1; end
    end else if (m_pend && cnt == 0) begin
      m_val = m_pv; m_pend = 0;
    end
    if (we && addr == 2'd1) m_lo = wd;
    n_irq = match & m_ctrl[6];
    @(posedge clk);
    @(negedge clk);
    if (irq) irq_cnt++;
    chk(act_tag(act), {15'd0, out}, {15'd0, m_out});
    if (model_on) begin
      chk("R11", {15'd0, irq}, {15'd0, n_irq});
      chk(addr == 2'd0 ? "R2" : (m_pend ? "R9" : "R8"), {8'd0, rdata}, {8'd0, exp_rd(addr)});
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr = a; wd = d; we = 1;
    tick();
    we = 0;
  endtask

  task automatic rd_chk(logic [1:0] a, logic [7:0] e, string req);
    addr = a;
    tick();
    chk(req, {8'd0, rdata}, {8'd0, e});
  endtask

  task automatic cap_step(logic [15:0] c, logic p, logic [15:0] e, int e_irq, string req);
    cnt = c; pin = p; irq_cnt = 0;
    repeat (4) tick();
    chk(req, irq_cnt, e_irq);
    rd_chk(2'd1, e[7:0], req);
    rd_chk(2'd2, e[15:8], req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {15'd0, out}, 16'd0);
    chk("R1", {15'd0, irq}, 16'd0);
    chk("R1", {8'd0, rdata}, 16'h0040);
    rst_n = 1;
    @(negedge clk);
    rd_chk(2'd1, 8'h00, "R1");
    rd_chk(2'd2, 8'h00, "R1");

    // R3 capture edges, R4 radio source, R11 masking
    wr(2'd0, 8'h41);
    cap_step(16'h1234, 1, 16'h1234, 1, "R3");
    cap_step(16'h2222, 0, 16'h1234, 0, "R3");
    wr(2'd0, 8'h42);
    cap_step(16'h3333, 1, 16'h1234, 0, "R3");
    cap_step(16'h4444, 0, 16'h4444, 1, "R3");
    wr(2'd0, 8'h43);
    cap_step(16'h5555, 1, 16'h5555, 1, "R3");
    cap_step(16'h6666, 0, 16'h6666, 1, "R3");
    wr(2'd0, 8'h40);
    cap_step(16'h7777, 1, 16'h6666, 0, "R3");
    wr(2'd0, 8'hC3);
    cap_step(16'h8888, 0, 16'h6666, 0, "R4");
    cnt = 16'h9999; radio = 1; irq_cnt = 0;
    tick();
    radio = 0; cnt = 16'h1111;
    repeat (2) tick();
    chk("R4", irq_cnt, 1);
    rd_chk(2'd2, 8'h99, "R4");
    wr(2'd0, 8'h03);
    cap_step(16'hAAAA, 1, 16'hAAAA, 0, "R11");

    // R10 immediate load in capture mode, R8 staging
    wr(2'd0, 8'h40);
    wr(2'd1, 8'hAB);
    wr(2'd2, 8'hCD);
    model_on = 1;
    rd_chk(2'd1, 8'hAB, "R10");
    rd_chk(2'd2, 8'hCD, "R10");
    wr(2'd1, 8'h11);
    rd_chk(2'd1, 8'hAB, "R8");

    // R9 deferral, newest pending wins
    wr(2'd0, 8'h44);
    cnt = 16'h0100;
    wr(2'd1, 8'h20);
    wr(2'd2, 8'h00);
    rd_chk(2'd2, 8'hCD, "R9");
    wr(2'd1, 8'h30);
    wr(2'd2, 8'h00);
    rd_chk(2'd1, 8'hAB, "R9");
    cnt = 16'h0000;
    rd_chk(2'd1, 8'h30, "R10");
    rd_chk(2'd2, 8'h00, "R9");

    // R5 set then R2 init keeps action
    cnt = 16'h0030;
    tick();
    chk("R5", {15'd0, out}, 16'd1);
    wr(2'd0, 8'h7C);
    chk("R2", {15'd0, out}, 16'd0);
    rd_chk(2'd0, 8'h44, "R2");

    // random compare traffic
    for (int s = 0; s < 40; s++) begin
      wr(2'd0, {1'b0, 1'($urandom % 2), 3'($urandom % 8), 1'b1, 2'b00});
      updown = 1'($urandom % 2);
      if ($urandom % 2 == 1) begin
        cnt = 16'h0001 + 16'($urandom % 200);
        wr(2'd1, 8'($urandom));
        wr(2'd2, 8'($urandom % 2));
      end
      for (int t = 0; t < 50; t++) begin
        case ($urandom % 6)
          0:       cnt = 16'h0000;
          1, 2:    cnt = m_val;
          3:       cnt = m_pv;
          default: cnt = 16'($urandom % 512);
        endcase
        down = 1'($urandom % 2);
        ch0  = ($urandom % 4) == 0;
        addr = 2'($urandom % 4);
        tick();
      end
      ch0 = 0;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule